// File: doc/BRIEF.md
# Power-Fail Autosave and Power-Up Restore Sequencer

This block watches two digitised supply-monitor flags. One says the supply is under the switch-over threshold and the other says it is under the reset threshold. When the supply starts to fail, the block asks a shared store/busy line to go low for a fixed warning window. At the end of that window it decides whether to launch an automatic save of the volatile array into the nonvolatile array. It saves only when the line really went low and the array holds unsaved writes.

Whenever the supply has gone under the reset threshold, the block latches a restore request. It runs the restore as soon as the supply climbs back above the switch-over threshold. The restore has two phases: the volatile array is first cleared, then loaded from the nonvolatile array.

A strap input turns off the automatic save. An explicit save request from software or a pin is also accepted while the supply is healthy. The block gates array writes whenever the supply is low or a transfer is running. Every duration is a parameter counted in clock cycles.

Top module: `psq_power_seq`

## Requirements
- R1: While reset is asserted, and until the supply first reads healthy, busy_pull_o, save_go_o, save_done_o, restore_clear_o, restore_load_o and restore_done_o are all low. A restore request is pending when reset is released.
- R2: A 0-to-1 change on below_switch_i, seen while idle with inhibit_i low, drives busy_pull_o high for exactly PULSE_CYC cycles. This warning window starts in the cycle after the change is sampled.
- R3: In the last warning cycle, busy_line_i may be low (line actually pulled) while dirty_i is high. In that case a save starts: save_go_o pulses high for one cycle, busy_pull_o stays high for SAVE_CYC further cycles, and save_done_o then pulses for one cycle.
- R4: If dirty_i is low in the last warning cycle, busy_pull_o is released after the warning window and no save starts.
- R5: If busy_line_i is still high in the last warning cycle, the pull is dropped after the warning window and the automatic save is abandoned. This holds whatever dirty_i is.
- R6: With inhibit_i high, a supply drop produces no pull on the busy line and no save.
- R7: below_switch_i may fall while a restore is pending. From the next cycle, restore_clear_o is high for CLEAR_CYC cycles and then restore_load_o is high for LOAD_CYC cycles, never both at once. restore_done_o then pulses for one cycle, and the request is cleared.
- R8: A dip above the reset threshold (below_switch_i high, below_reset_i always low) causes no restore when the supply recovers.
- R9: sram_inhibit_o is high whenever below_switch_i is high or a save or restore phase is running. It is low when idle with a healthy supply.
- R10: An ext_save_i pulse, given while idle with below_switch_i low, starts a save whatever the value of dirty_i. That save gives a save_go_o pulse, SAVE_CYC cycles of busy_pull_o, then a save_done_o pulse. ext_save_i is ignored while below_switch_i is high.
- R11: A new supply drop during either restore phase stops the restore in the next cycle, with no restore_done_o. The request stays latched, and the full restore runs again after the next recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| below_switch_i | input | 1 | Supply is under the switch-over threshold |
| below_reset_i | input | 1 | Supply is under the reset threshold |
| inhibit_i | input | 1 | Strap: disables automatic save on power loss |
| dirty_i | input | 1 | Array written since the last nonvolatile transfer |
| busy_line_i | input | 1 | Sensed level of the store/busy line (low = pulled) |
| ext_save_i | input | 1 | Explicit save request from software or pin |
| busy_pull_o | output | 1 | Request to pull the store/busy line low |
| save_go_o | output | 1 | One-cycle save trigger |
| save_done_o | output | 1 | One-cycle pulse at the end of a save |
| restore_clear_o | output | 1 | Restore phase 1: clear the volatile array |
| restore_load_o | output | 1 | Restore phase 2: copy nonvolatile data in |
| restore_done_o | output | 1 | One-cycle pulse at the end of a restore |
| sram_inhibit_o | output | 1 | Blocks array writes |

## Verification
The supply-drop response is driven through a table of strap, dirty-flag and line-behaviour combinations. Counting the pull, trigger and done cycles for each row separates four outcomes: a full save, a pull-only warning, an abandoned attempt on a stuck line, and a strap-suppressed drop. The restore path is tried three ways: from reset, after a deep brown-out cut short by a second drop, and after a shallow dip. Comparing phase lengths and done pulses shows whether the request latch really holds across a cancel and stays clear after a shallow dip. Explicit save requests are applied with the supply healthy and with it low, to tell acceptance from gating.

// File: rtl/psq_pkg.sv
package psq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WARN,
    ST_SAVE,
    ST_CLR,
    ST_LOAD
  } psq_state_e;

  localparam int unsigned DEF_PULSE_CYC = 100;
  localparam int unsigned DEF_SAVE_CYC  = 1_000_000;
  localparam int unsigned DEF_CLEAR_CYC = 5_000;
  localparam int unsigned DEF_LOAD_CYC  = 50_000;
endpackage

// File: rtl/psq_supply_track.sv
module psq_supply_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic below_switch_i,
  input  logic below_reset_i,
  input  logic pend_clr_i,
  output logic fall_o,
  output logic pend_o
);
  logic low_q;
  logic pend_q;

  // low_q resets high so a supply that is low at reset is not seen as a new drop
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_q  <= 1'b1;
      pend_q <= 1'b1;
    end else begin
      low_q <= below_switch_i;
      if (below_reset_i)   pend_q <= 1'b1;
      else if (pend_clr_i) pend_q <= 1'b0;
    end
  end

  assign fall_o = below_switch_i && !low_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/psq_timer.sv
module psq_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/psq_ctrl.sv
module psq_ctrl
  import psq_pkg::*;
#(
  parameter int unsigned PULSE_CYC = DEF_PULSE_CYC,
  parameter int unsigned SAVE_CYC  = DEF_SAVE_CYC,
  parameter int unsigned CLEAR_CYC = DEF_CLEAR_CYC,
  parameter int unsigned LOAD_CYC  = DEF_LOAD_CYC
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic below_switch_i,
  input  logic fall_i,
  input  logic pend_i,
  input  logic inhibit_i,
  input  logic dirty_i,
  input  logic busy_line_i,
  input  logic ext_save_i,
  output logic pend_clr_o,
  output logic busy_pull_o,
  output logic save_active_o,
  output logic save_go_o,
  output logic save_done_o,
  output logic restore_clear_o,
  output logic restore_load_o,
  output logic restore_done_o
);
  localparam int unsigned MAX_AB = (PULSE_CYC > SAVE_CYC) ? PULSE_CYC : SAVE_CYC;
  localparam int unsigned MAX_CD = (CLEAR_CYC > LOAD_CYC) ? CLEAR_CYC : LOAD_CYC;
  localparam int unsigned MAX_C  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int unsigned CNT_W  = (MAX_C < 2) ? 1 : $clog2(MAX_C);
  localparam logic [CNT_W-1:0] PULSE_LD = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] SAVE_LD  = CNT_W'(SAVE_CYC - 1);
  localparam logic [CNT_W-1:0] CLEAR_LD = CNT_W'(CLEAR_CYC - 1);
  localparam logic [CNT_W-1:0] LOAD_LD  = CNT_W'(LOAD_CYC - 1);

  psq_state_e       state_q, state_d;
  logic             tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  logic             go_set, sdone_set, rdone_set;
  logic             go_q, sdone_q, rdone_q;

  psq_timer #(.W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  always_comb begin
    state_d   = state_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    go_set    = 1'b0;
    sdone_set = 1'b0;
    rdone_set = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        // a pending restore takes priority over any save
        if (pend_i && !below_switch_i) begin
          state_d = ST_CLR; tmr_load = 1'b1; tmr_val = CLEAR_LD;
        end else if (fall_i && !inhibit_i) begin
          state_d = ST_WARN; tmr_load = 1'b1; tmr_val = PULSE_LD;
        end else if (ext_save_i && !below_switch_i) begin
          state_d = ST_SAVE; tmr_load = 1'b1; tmr_val = SAVE_LD; go_set = 1'b1;
        end
      end
      ST_WARN: begin
        if (tmr_zero) begin
          if (!busy_line_i && dirty_i) begin
            state_d = ST_SAVE; tmr_load = 1'b1; tmr_val = SAVE_LD; go_set = 1'b1;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_SAVE: begin
        if (tmr_zero) begin
          state_d = ST_IDLE; sdone_set = 1'b1;
        end
      end
      ST_CLR: begin
        if (fall_i) begin
          state_d = ST_IDLE;
        end else if (tmr_zero) begin
          state_d = ST_LOAD; tmr_load = 1'b1; tmr_val = LOAD_LD;
        end
      end
      ST_LOAD: begin
        if (fall_i) begin
          state_d = ST_IDLE;
        end else if (tmr_zero) begin
          state_d = ST_IDLE; rdone_set = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      go_q    <= 1'b0;
      sdone_q <= 1'b0;
      rdone_q <= 1'b0;
    end else begin
      state_q <= state_d;
      go_q    <= go_set;
      sdone_q <= sdone_set;
      rdone_q <= rdone_set;
    end
  end

  assign pend_clr_o      = rdone_set;
  assign busy_pull_o     = (state_q == ST_WARN) || (state_q == ST_SAVE);
  assign save_active_o   = (state_q == ST_SAVE);
  assign restore_clear_o = (state_q == ST_CLR);
  assign restore_load_o  = (state_q == ST_LOAD);
  assign save_go_o       = go_q;
  assign save_done_o     = sdone_q;
  assign restore_done_o  = rdone_q;
endmodule

// File: rtl/psq_power_seq.sv
module psq_power_seq
  import psq_pkg::*;
#(
  parameter int unsigned PULSE_CYC = DEF_PULSE_CYC,
  parameter int unsigned SAVE_CYC  = DEF_SAVE_CYC,
  parameter int unsigned CLEAR_CYC = DEF_CLEAR_CYC,
  parameter int unsigned LOAD_CYC  = DEF_LOAD_CYC
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic below_switch_i,
  input  logic below_reset_i,
  input  logic inhibit_i,
  input  logic dirty_i,
  input  logic busy_line_i,
  input  logic ext_save_i,
  output logic busy_pull_o,
  output logic save_go_o,
  output logic save_done_o,
  output logic restore_clear_o,
  output logic restore_load_o,
  output logic restore_done_o,
  output logic sram_inhibit_o
);
  logic fall, pend, pend_clr, save_active;

  psq_supply_track u_track (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .below_switch_i (below_switch_i),
    .below_reset_i  (below_reset_i),
    .pend_clr_i     (pend_clr),
    .fall_o         (fall),
    .pend_o         (pend)
  );

  psq_ctrl #(
    .PULSE_CYC (PULSE_CYC),
    .SAVE_CYC  (SAVE_CYC),
    .CLEAR_CYC (CLEAR_CYC),
    .LOAD_CYC  (LOAD_CYC)
  ) u_ctrl (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .below_switch_i  (below_switch_i),
    .fall_i          (fall),
    .pend_i          (pend),
    .inhibit_i       (inhibit_i),
    .dirty_i         (dirty_i),
    .busy_line_i     (busy_line_i),
    .ext_save_i      (ext_save_i),
    .pend_clr_o      (pend_clr),
    .busy_pull_o     (busy_pull_o),
    .save_active_o   (save_active),
    .save_go_o       (save_go_o),
    .save_done_o     (save_done_o),
    .restore_clear_o (restore_clear_o),
    .restore_load_o  (restore_load_o),
    .restore_done_o  (restore_done_o)
  );

  assign sram_inhibit_o = below_switch_i || save_active || restore_clear_o || restore_load_o;
endmodule

// File: rtl/psq_checker.sv
module psq_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic below_switch_i,
  input logic below_reset_i,
  input logic inhibit_i,
  input logic dirty_i,
  input logic busy_line_i,
  input logic ext_save_i,
  input logic busy_pull_o,
  input logic save_go_o,
  input logic save_done_o,
  input logic restore_clear_o,
  input logic restore_load_o,
  input logic restore_done_o,
  input logic sram_inhibit_o
);
  p_go_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_go_o |=> !save_go_o);

  p_go_pulls_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_go_o |-> busy_pull_o);

  p_done_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_done_o |=> !save_done_o);

  p_phase_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(restore_clear_o && restore_load_o));

  p_done_after_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_done_o |-> $past(restore_load_o));

  p_strap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(below_switch_i) && inhibit_i && !busy_pull_o) |=> !busy_pull_o);

  p_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (below_switch_i || restore_clear_o || restore_load_o) |-> sram_inhibit_o);

  p_cancel_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(below_switch_i) && (restore_clear_o || restore_load_o))
      |=> (!restore_clear_o && !restore_load_o && !restore_done_o));
endmodule

bind psq_power_seq psq_checker u_chk (.*);

// File: tb/psq_power_seq_tb.sv
module psq_power_seq_tb;
  localparam int P_PULSE = 4;
  localparam int P_SAVE  = 10;
  localparam int P_CLEAR = 3;
  localparam int P_LOAD  = 5;
  localparam int N_VEC   = 6;

  // {inhibit, dirty, stuck_high, pull_cycles[7:0], save_expected}
  localparam logic [11:0] VEC [N_VEC] = '{
    {1'b0, 1'b1, 1'b0, 8'(P_PULSE + P_SAVE), 1'b1},
    {1'b0, 1'b0, 1'b0, 8'(P_PULSE),          1'b0},
    {1'b0, 1'b1, 1'b1, 8'(P_PULSE),          1'b0},
    {1'b1, 1'b1, 1'b0, 8'd0,                 1'b0},
    {1'b1, 1'b0, 1'b0, 8'd0,                 1'b0},
    {1'b0, 1'b0, 1'b1, 8'(P_PULSE),          1'b0}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic below_switch = 1'b1, below_reset = 1'b1, inhibit = 1'b0, dirty = 1'b0;
  logic stuck_high = 1'b0, ext_save = 1'b0;
  logic busy_line;
  logic busy_pull, save_go, save_done, r_clear, r_load, r_done, s_inh;

  int n_chk = 0, n_fail = 0;
  int c_pull, c_go, c_sdone, c_clr, c_load, c_rdone, c_inh;

  always #10 clk = ~clk;

  assign busy_line = stuck_high ? 1'b1 : !busy_pull;

  psq_power_seq #(
    .PULSE_CYC (P_PULSE),
    .SAVE_CYC  (P_SAVE),
    .CLEAR_CYC (P_CLEAR),
    .LOAD_CYC  (P_LOAD)
  ) u_dut (
    .clk_i           (clk),
    .rst_ni          (rst_ni),
    .below_switch_i  (below_switch),
    .below_reset_i   (below_reset),
    .inhibit_i       (inhibit),
    .dirty_i         (dirty),
    .busy_line_i     (busy_line),
    .ext_save_i      (ext_save),
    .busy_pull_o     (busy_pull),
    .save_go_o       (save_go),
    .save_done_o     (save_done),
    .restore_clear_o (r_clear),
    .restore_load_o  (r_load),
    .restore_done_o  (r_done),
    .sram_inhibit_o  (s_inh)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_counts();
    c_pull = 0; c_go = 0; c_sdone = 0; c_clr = 0; c_load = 0; c_rdone = 0; c_inh = 0;
  endtask

  task automatic window(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      c_pull  += int'(busy_pull);
      c_go    += int'(save_go);
      c_sdone += int'(save_done);
      c_clr   += int'(r_clear);
      c_load  += int'(r_load);
      c_rdone += int'(r_done);
      c_inh   += int'(s_inh);
      ext_save = 1'b0;
    end
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1 reset state, R9 gating while supply low
    repeat (3) @(negedge clk);
    check("R1 pull in reset", int'(busy_pull), 0);
    check("R1 go/done in reset", int'(save_go | save_done | r_done), 0);
    check("R1 restore phases in reset", int'(r_clear | r_load), 0);
    check("R9 inhibit while low", int'(s_inh), 1);
    rst_ni = 1'b1;
    below_reset = 1'b0;
    clear_counts();
    window(4);
    check("R1 idle before supply ok", c_pull + c_go + c_clr + c_load, 0);

    // R1/R7 power-up restore from the latched request
    below_switch = 1'b0;
    @(negedge clk);
    check("R7 clear starts next cycle", int'(r_clear), 1);
    clear_counts();
    c_clr = 1; c_inh = 1;
    window(20);
    check("R7 clear cycles", c_clr, P_CLEAR);
    check("R7 load cycles", c_load, P_LOAD);
    check("R7 done pulses", c_rdone, 1);
    check("R9 inhibit during restore", c_inh, P_CLEAR + P_LOAD);

    // R2-R6, R8: supply-drop table
    for (int v = 0; v < N_VEC; v++) begin
      inhibit    = VEC[v][11];
      dirty      = VEC[v][10];
      stuck_high = VEC[v][9];
      clear_counts();
      below_switch = 1'b1;
      window(40);
      below_switch = 1'b0;
      window(8);
      check($sformatf("R2/R4/R5/R6 pull cycles v%0d", v), c_pull, int'(VEC[v][8:1]));
      check($sformatf("R3/R5/R6 save go v%0d", v), c_go, int'(VEC[v][0]));
      check($sformatf("R3 save done v%0d", v), c_sdone, int'(VEC[v][0]));
      check($sformatf("R8 no restore v%0d", v), c_clr + c_load + c_rdone, 0);
    end
    stuck_high = 1'b0;
    inhibit = 1'b0;

    // R10 explicit save, dirty low
    dirty = 1'b0;
    clear_counts();
    ext_save = 1'b1;
    window(20);
    check("R10 go", c_go, 1);
    check("R10 pull cycles", c_pull, P_SAVE);
    check("R10 done", c_sdone, 1);
    check("R9 inhibit during save", c_inh, P_SAVE);

    // R10 ignored while supply low
    inhibit = 1'b1;
    below_switch = 1'b1;
    window(3);
    clear_counts();
    ext_save = 1'b1;
    window(20);
    check("R10 ignored when low: go", c_go, 0);
    check("R10 ignored when low: pull", c_pull, 0);
    below_switch = 1'b0;
    window(3);

    // R11 restore cancelled by a new drop, then rerun
    below_switch = 1'b1;
    below_reset = 1'b1;
    window(2);
    below_reset = 1'b0;
    window(2);
    below_switch = 1'b0;
    @(negedge clk);
    check("R11 restore started", int'(r_clear), 1);
    below_switch = 1'b1;
    @(negedge clk);
    check("R11 cancel phases", int'(r_clear | r_load), 0);
    check("R11 cancel no done", int'(r_done), 0);
    clear_counts();
    window(10);
    check("R11 stays stopped", c_clr + c_load + c_rdone, 0);
    clear_counts();
    below_switch = 1'b0;
    window(20);
    check("R11 rerun clear", c_clr, P_CLEAR);
    check("R11 rerun load", c_load, P_LOAD);
    check("R11 rerun done", c_rdone, 1);
    check("R9 inhibit low when idle", int'(s_inh), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule